// File: doc/BRIEF.md
# Packed FP32 Square Root Unit

This execution unit takes a vector of single-precision values and returns the IEEE-754 square root of every 32-bit lane, rounded to nearest-even. Lane `i` reads `src[32i+31:32i]` and writes `result[32i+31:32i]`. A two-bit encoding selector chooses how many lanes are computed and what happens to the upper half of the destination. The upper half is either copied from the old destination contents, cleared, or filled with computed roots.

A 4-bit operand-selector field must read all ones in the two extended encodings. When it does not, the operation is refused. The unit then signals an undefined-opcode fault, hands back the old destination unchanged and raises no flags.

Work starts with a one-cycle `start` pulse. Each lane then runs a restoring digit recurrence that produces one root bit per clock. `busy` covers the whole operation, and `done` pulses for one cycle when `result` and the sticky flags are ready. The flags report an invalid operation, an inexact result and a denormal operand.

Top module: `vsqrt_unit`

## Requirements
- R1: For a positive normal input, each lane returns the correctly rounded (round-to-nearest-even) FP32 square root at the same bit position as its source lane.
- R2: With mode 2'b00 (legacy 128-bit), lanes 0-3 are computed, result bits [255:128] equal the old destination bits, and the vvvv field is ignored.
- R3: With mode 2'b01 (extended 128-bit) and vvvv = 4'b1111, lanes 0-3 are computed and result bits [255:128] are zero.
- R4: With mode 2'b10 or 2'b11 (extended 256-bit) and vvvv = 4'b1111, all eight lanes are computed.
- R5: With mode 2'b01, 2'b10 or 2'b11 and vvvv other than 4'b1111, done pulses one cycle after the start edge with ud_fault = 1, result equal to the old destination, and all three flags clear.
- R6: +0 returns +0, -0 returns -0, +infinity returns +infinity, and a quiet NaN (bit 22 set) is returned unchanged with no invalid flag.
- R7: Any negative nonzero input, including -infinity and negative denormals, returns 32'hFFC00000 and sets the invalid flag. A signalling NaN (bit 22 clear) is returned with bit 22 set and sets the invalid flag.
- R8: A denormal input (exponent field zero, fraction nonzero) sets the denormal flag and yields the correctly rounded root of its true value.
- R9: The inexact flag is set exactly when some computed lane's root is not exact; special-case lanes never set it.
- R10: Each flag is the OR over active lanes only. Lanes 4-7 in a 128-bit mode do not contribute. Flags, result and ud_fault are valid when done is high and hold until the next operation finishes.
- R11: After an accepted start, busy is high for 26 cycles and done is high for exactly one cycle, 26 cycles after the start edge, with busy low. A start while busy is ignored.
- R12: After reset, busy, done, ud_fault, all flags and result are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted when not busy) |
| src | input | 256 | Source vector, eight FP32 lanes |
| dst_old | input | 256 | Previous destination contents |
| mode | input | 2 | 00 legacy 128, 01 extended 128, 1x extended 256 |
| vvvv | input | 4 | Operand-selector field, must be 4'b1111 in extended modes |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 256 | Merged destination value |
| flg_invalid | output | 1 | Invalid-operation flag |
| flg_inexact | output | 1 | Inexact-result flag |
| flg_denorm | output | 1 | Denormal-operand flag |
| ud_fault | output | 1 | Undefined-opcode fault |

## Verification
The bench goes after the rounding of irrational roots such as sqrt(2) and pi. A recurrence short of one bit, or one that drops the sticky remainder, returns results one ulp off and misses the inexact flag. Denormals at both ends of the range and negative denormals are driven next: a wrong normalisation shift or an exponent halved with the wrong rounding for odd negative exponents gives a root off by a factor of two. Signalling against quiet NaN and negative zero against negative nonzero are included, because an off-by-one in the sign or quiet-bit tests swaps NaN and zero outputs. Upper-lane poison values in 128-bit modes, a busy-time restart and refused encodings catch flags leaking from inactive lanes, an operation that restarts and corrupts its operands, and a fault that still writes the destination.

// File: rtl/fsqrt_pkg.sv
package fsqrt_pkg;
  localparam int FP_W   = 32;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int SIG_W  = FRAC_W + 1;        // significand with hidden bit
  localparam int RB     = SIG_W + 1;         // root bits incl. round bit
  localparam int XW     = 2 * RB;            // radicand width
  localparam int REM_W  = RB + 3;            // partial remainder width
  localparam int ITERS  = RB;                // recurrence steps
  localparam int BIAS   = 127;
  localparam logic [FP_W-1:0] QNAN_DEF = 32'hFFC00000;

  localparam logic [1:0] ENC_LEG  = 2'b00;
  localparam logic [1:0] ENC_V128 = 2'b01;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FLT} ctrl_st_t;
endpackage

// File: rtl/fsqrt_lane.sv
module fsqrt_lane
  import fsqrt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             step,
  input  logic [FP_W-1:0]  opnd,
  output logic [FP_W-1:0]  res,
  output logic             f_inv,
  output logic             f_den,
  output logic             f_inex
);
  localparam int LW = $clog2(FRAC_W);

  logic              sgn;
  logic [EXP_W-1:0]  bexp;
  logic [FRAC_W-1:0] frac;
  assign {sgn, bexp, frac} = opnd;

  logic is_zero, is_sub, is_max;
  assign is_zero = (bexp == '0) && (frac == '0);
  assign is_sub  = (bexp == '0) && (frac != '0);
  assign is_max  = (bexp == '1);

  // position of the leading one in a denormal fraction
  logic [LW-1:0] lead;
  always_comb begin
    lead = '0;
    for (int i = 0; i < FRAC_W; i++)
      if (frac[i]) lead = LW'(i);
  end

  logic signed [EXP_W+1:0] ue;
  logic [SIG_W-1:0]        sig;
  logic [XW-1:0]           xin;
  logic [EXP_W-1:0]        rexp;
  always_comb begin
    if (is_sub) begin
      ue  = $signed({{(EXP_W+2-LW){1'b0}}, lead}) - (EXP_W+2)'(BIAS + FRAC_W - 1);
      sig = {1'b0, frac} << (FRAC_W - int'(lead));
    end else begin
      ue  = $signed({2'b00, bexp}) - (EXP_W+2)'(BIAS);
      sig = {1'b1, frac};
    end
    xin  = ue[0] ? {sig, {(XW-SIG_W){1'b0}}} : {1'b0, sig, {(XW-SIG_W-1){1'b0}}};
    rexp = EXP_W'((ue >>> 1) + (EXP_W+2)'(BIAS));
  end

  logic              spec_n, inv_n;
  logic [FP_W-1:0]   sval_n;
  always_comb begin
    spec_n = 1'b1;
    inv_n  = 1'b0;
    sval_n = opnd;
    if (is_max && frac != '0) begin
      sval_n     = opnd;
      sval_n[FRAC_W-1] = 1'b1;
      inv_n      = ~frac[FRAC_W-1];
    end else if (is_zero) begin
      sval_n = opnd;
    end else if (sgn) begin
      sval_n = QNAN_DEF;
      inv_n  = 1'b1;
    end else if (is_max) begin
      sval_n = opnd;
    end else begin
      spec_n = 1'b0;
    end
  end

  logic              spec_q, inv_q, den_q;
  logic [FP_W-1:0]   sval_q;
  logic [XW-1:0]     x_q;
  logic [REM_W-1:0]  rem_q;
  logic [RB-1:0]     root_q;
  logic [EXP_W-1:0]  ex_q;

  logic [REM_W-1:0]  rem_sh, trial;
  logic              ge;
  always_comb begin
    rem_sh = {rem_q[REM_W-3:0], x_q[XW-1 -: 2]};
    trial  = {{(REM_W-RB-2){1'b0}}, root_q, 2'b01};
    ge     = (rem_sh >= trial);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      spec_q <= 1'b0; inv_q <= 1'b0; den_q <= 1'b0;
      sval_q <= '0; x_q <= '0; rem_q <= '0; root_q <= '0; ex_q <= '0;
    end else if (load) begin
      spec_q <= spec_n;
      inv_q  <= inv_n;
      den_q  <= is_sub;
      sval_q <= sval_n;
      x_q    <= xin;
      ex_q   <= rexp;
      rem_q  <= '0;
      root_q <= '0;
    end else if (step) begin
      x_q    <= x_q << 2;
      rem_q  <= ge ? rem_sh - trial : rem_sh;
      root_q <= {root_q[RB-2:0], ge};
    end
  end

  logic             sticky, up, carry;
  logic [SIG_W:0]   mr;
  always_comb begin
    sticky = |rem_q;
    up     = root_q[0] & (sticky | root_q[1]);
    mr     = {1'b0, root_q[RB-1:1]} + {{SIG_W{1'b0}}, up};
    carry  = mr[SIG_W];
    res    = spec_q ? sval_q
                    : {1'b0, ex_q + {{(EXP_W-1){1'b0}}, carry},
                       carry ? {FRAC_W{1'b0}} : mr[FRAC_W-1:0]};
    f_inv  = inv_q;
    f_den  = den_q;
    f_inex = ~spec_q & (sticky | root_q[0]);
  end
endmodule

// File: rtl/fsqrt_ctrl.sv
module fsqrt_ctrl
  import fsqrt_pkg::*;
#(
  parameter int STEPS = ITERS
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic fault_req,
  output logic busy,
  output logic accept,
  output logic load,
  output logic step,
  output logic fin_ok,
  output logic fin_flt
);
  localparam int CW = $clog2(STEPS + 1);

  ctrl_st_t        st;
  logic [CW-1:0]   cnt;

  assign busy    = (st != ST_IDLE);
  assign accept  = start && (st == ST_IDLE);
  assign load    = accept && !fault_req;
  assign step    = (st == ST_RUN) && (cnt != CW'(STEPS));
  assign fin_ok  = (st == ST_RUN) && (cnt == CW'(STEPS));
  assign fin_flt = (st == ST_FLT);

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        ST_IDLE: if (accept) begin
          st  <= fault_req ? ST_FLT : ST_RUN;
          cnt <= '0;
        end
        ST_RUN: begin
          if (fin_ok) st <= ST_IDLE;
          else        cnt <= cnt + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vsqrt_unit.sv
module vsqrt_unit
  import fsqrt_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [LANES*32-1:0]   src,
  input  logic [LANES*32-1:0]   dst_old,
  input  logic [1:0]            mode,
  input  logic [3:0]            vvvv,
  output logic                  busy,
  output logic                  done,
  output logic [LANES*32-1:0]   result,
  output logic                  flg_invalid,
  output logic                  flg_inexact,
  output logic                  flg_denorm,
  output logic                  ud_fault
);
  localparam int DW   = LANES * FP_W;
  localparam int HALF = LANES / 2;

  logic fault_req, accept, load, step, fin_ok, fin_flt;
  assign fault_req = (mode != ENC_LEG) && (vvvv != 4'hF);

  fsqrt_ctrl #(.STEPS(ITERS)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .fault_req(fault_req),
    .busy(busy), .accept(accept), .load(load), .step(step),
    .fin_ok(fin_ok), .fin_flt(fin_flt)
  );

  logic [1:0]    mode_q;
  logic [DW-1:0] old_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      old_q  <= '0;
    end else if (accept) begin
      mode_q <= mode;
      old_q  <= dst_old;
    end
  end

  logic [FP_W-1:0] lane_res [LANES];
  logic [LANES-1:0] l_inv, l_den, l_inex, active;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    fsqrt_lane u_lane (
      .clk(clk), .rst(rst), .load(load), .step(step),
      .opnd(src[g*FP_W +: FP_W]),
      .res(lane_res[g]), .f_inv(l_inv[g]), .f_den(l_den[g]), .f_inex(l_inex[g])
    );
    assign active[g] = (g < HALF) || mode_q[1];
  end

  logic [DW-1:0] merged;
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      if (active[i])              merged[i*FP_W +: FP_W] = lane_res[i];
      else if (mode_q == ENC_LEG) merged[i*FP_W +: FP_W] = old_q[i*FP_W +: FP_W];
      else                        merged[i*FP_W +: FP_W] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done <= 1'b0; result <= '0; ud_fault <= 1'b0;
      flg_invalid <= 1'b0; flg_inexact <= 1'b0; flg_denorm <= 1'b0;
    end else begin
      done <= fin_ok | fin_flt;
      if (fin_ok) begin
        result      <= merged;
        ud_fault    <= 1'b0;
        flg_invalid <= |(l_inv  & active);
        flg_inexact <= |(l_inex & active);
        flg_denorm  <= |(l_den  & active);
      end else if (fin_flt) begin
        result      <= old_q;
        ud_fault    <= 1'b1;
        flg_invalid <= 1'b0;
        flg_inexact <= 1'b0;
        flg_denorm  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vsqrt_unit_chk.sv
module vsqrt_unit_chk #(
  parameter int LANES = 8,
  parameter int STEPS = 25
) (
  input logic                clk,
  input logic                rst,
  input logic                start,
  input logic                busy,
  input logic                done,
  input logic                ud_fault,
  input logic                flg_invalid,
  input logic                flg_inexact,
  input logic                flg_denorm,
  input logic [LANES*32-1:0] result,
  input logic [1:0]          mode_q
);
  localparam int CW = $clog2(STEPS + 2) + 1;
  logic [CW-1:0] bcnt;
  always_ff @(posedge clk) begin
    if (rst)       bcnt <= '0;
    else if (busy) bcnt <= bcnt + 1'b1;
    else           bcnt <= '0;
  end

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  a_r11_excl:       assert property (@(posedge clk) disable iff (rst) !(busy && done));
  a_r11_accept:     assert property (@(posedge clk) disable iff (rst) (start && !busy) |=> busy);
  a_r11_latency:    assert property (@(posedge clk) disable iff (rst)
                      done |-> bcnt == (ud_fault ? CW'(1) : CW'(STEPS + 1)));
  a_r5_no_flags:    assert property (@(posedge clk) disable iff (rst)
                      (done && ud_fault) |-> !(flg_invalid || flg_inexact || flg_denorm));
  a_r3_upper_zero:  assert property (@(posedge clk) disable iff (rst)
                      (done && !ud_fault && mode_q == 2'b01) |-> result[LANES*32-1:LANES*16] == '0);
  a_r10_hold:       assert property (@(posedge clk) disable iff (rst)
                      (!done && $past(!done)) |-> $stable(result));
endmodule

bind vsqrt_unit vsqrt_unit_chk #(.LANES(LANES), .STEPS(fsqrt_pkg::ITERS)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .ud_fault(ud_fault), .flg_invalid(flg_invalid), .flg_inexact(flg_inexact),
  .flg_denorm(flg_denorm), .result(result), .mode_q(mode_q)
);

// File: tb/tb_vsqrt_unit.sv
module tb_vsqrt_unit;
  localparam int LAT_OK  = 26;
  localparam int LAT_FLT = 1;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [255:0] src = '0, dst_old = '0, result;
  logic [1:0] mode = 2'b00;
  logic [3:0] vvvv = 4'hF;
  logic busy, done, flg_invalid, flg_inexact, flg_denorm, ud_fault;
  int nchk = 0, nerr = 0, cyc = 0;

  always #4 clk = ~clk;

  vsqrt_unit dut (.*);

  task automatic chk(input string rq, input logic [255:0] act, input logic [255:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      nerr++; nchk++;
      $display("FAIL R11 watchdog act=%0d exp=<100000", cyc);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  // behavioural FP32 square root: greedy bitwise integer root on the scaled radicand
  task automatic ref_lane(input logic [31:0] a, output logic [31:0] r,
                          output logic inv, output logic den, output logic inx);
    logic s; logic [7:0] e8; logic [22:0] f;
    longint sig, x, q, t, m; int e, odd, eh, p; bit exact;
    {s, e8, f} = a; inv = 0; den = 0; inx = 0; r = a;
    if (e8 == 8'hFF && f != 0) begin r = a | 32'h0040_0000; inv = !a[22]; end
    else if (e8 == 0 && f == 0) r = a;
    else if (s) begin r = 32'hFFC0_0000; inv = 1; den = (e8 == 0); end
    else if (e8 == 8'hFF) r = a;
    else begin
      if (e8 == 0) begin
        den = 1; p = 0;
        for (int i = 0; i < 23; i++) if (f[i]) p = i;
        sig = longint'(f) << (23 - p); e = p - 149;
      end else begin
        sig = longint'({1'b1, f}); e = int'(e8) - 127;
      end
      odd = e & 1;
      x = odd ? (sig << 26) : (sig << 25);
      eh = (e - odd) / 2;
      q = 0;
      for (int b = 24; b >= 0; b--) begin
        t = q | (longint'(1) << b);
        if (t * t <= x) q = t;
      end
      exact = (q * q == x); inx = !exact;
      m = q >> 1;
      if ((q & 1) && (!exact || (m & 1))) m++;
      if (m == (longint'(1) << 24)) begin m = longint'(1) << 23; eh++; end
      r = {1'b0, 8'(eh + 127), m[22:0]};
    end
  endtask

  task automatic run_op(input logic [255:0] s, input logic [255:0] o, input logic [1:0] md,
                        input logic [3:0] vv, input bit poke, input string rq);
    logic [255:0] er; logic ei = 0, ed = 0, ex = 0, ef; int lat;
    ef = (md != 2'b00) && (vv != 4'hF);
    for (int i = 0; i < 8; i++) begin
      logic [31:0] lr; logic li, ld, lx; bit act;
      act = (i < 4) || md[1];
      ref_lane(s[i*32 +: 32], lr, li, ld, lx);
      if (act) begin er[i*32 +: 32] = lr; ei |= li; ed |= ld; ex |= lx; end
      else er[i*32 +: 32] = (md == 2'b00) ? o[i*32 +: 32] : 32'h0;
    end
    if (ef) begin er = o; ei = 0; ed = 0; ex = 0; end
    lat = ef ? LAT_FLT : LAT_OK;
    @(negedge clk);
    src = s; dst_old = o; mode = md; vvvv = vv; start = 1;
    @(posedge clk); #1;
    start = 0;
    chk("R11 busy after start", busy, 1'b1);
    for (int c = 1; c <= lat; c++) begin
      @(posedge clk); #1;
      if (poke && c == 4) begin start = 1; src = {8{32'h4080_0000}}; mode = 2'b10; end
      if (poke && c == 5) begin start = 0; src = s; end
      if (c < lat) chk("R11 busy/done mid", {busy, done}, 2'b10);
      else begin
        chk("R11 busy/done end", {busy, done}, 2'b01);
        chk({rq, " result"}, result, er);
        chk({rq, " flags inv/inx/den/ud"}, {flg_invalid, flg_inexact, flg_denorm, ud_fault},
            {ei, ex, ed, ef});
      end
    end
    @(posedge clk); #1;
    chk("R11 single done pulse", {busy, done}, 2'b00);
    chk("R10 result held", result, er);
  endtask

  logic [255:0] v;
  logic [31:0] lcg;

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(posedge clk); #1;
    chk("R12 reset ctl", {busy, done, ud_fault, flg_invalid, flg_inexact, flg_denorm}, 6'b0);
    chk("R12 reset result", result, '0);

    // R1 R4 R9: normal values, exact and irrational roots
    v = {32'h4049_0FDB, 32'h3E80_0000, 32'h42C8_0000, 32'h3F00_0000,
         32'h3F80_0000, 32'h4110_0000, 32'h4000_0000, 32'h4080_0000};
    run_op(v, {8{32'hDEAD_BEEF}}, 2'b10, 4'hF, 0, "R1 R4 R9 normals");
    // R1 R9 exact only: inexact must be clear
    v = {32'h4080_0000, 32'h3F80_0000, 32'h4110_0000, 32'h3E80_0000,
         32'h4080_0000, 32'h3F80_0000, 32'h4110_0000, 32'h3E80_0000};
    run_op(v, '0, 2'b10, 4'hF, 0, "R9 exact roots");
    // R6 R7 R8 specials across all lanes
    v = {32'h0000_0001, 32'hFF80_0000, 32'hBF80_0000, 32'h7F80_0001,
         32'h7FC1_2345, 32'h7F80_0000, 32'h0000_0000, 32'h8000_0000};
    run_op(v, '0, 2'b10, 4'hF, 0, "R6 R7 R8 specials");
    // R6 quiet NaN and zeros only: no invalid
    v = {32'h7FC0_0000, 32'h0000_0000, 32'h8000_0000, 32'h7F80_0000,
         32'hFFC0_0001, 32'h7FFF_FFFF, 32'h8000_0000, 32'h0000_0000};
    run_op(v, '0, 2'b11, 4'hF, 0, "R6 R4 passthrough mode3");
    // R2 R8 R7 legacy with vvvv ignored, denormals incl negative
    v = {{4{32'hBF80_0000}}, 32'h4000_0000, 32'h8000_0001, 32'h007F_FFFF, 32'h0040_0000};
    run_op(v, {8{32'hA5A5_5A5A}}, 2'b00, 4'h0, 0, "R2 R7 R8 legacy denorm");
    // R10 inactive upper lanes carry negatives and denormals, lower lanes clean
    v = {32'hBF80_0000, 32'h0000_0003, 32'h7F80_0001, 32'hC000_0000,
         32'h4080_0000, 32'h3F80_0000, 32'h4110_0000, 32'h4080_0000};
    run_op(v, {8{32'h1234_5678}}, 2'b00, 4'hF, 0, "R10 legacy masked flags");
    run_op(v, {8{32'h1234_5678}}, 2'b01, 4'hF, 0, "R3 R10 ext128 zero upper");
    // R11 start while busy ignored
    v = {8{32'h4000_0000}};
    run_op(v, {8{32'hCAFE_F00D}}, 2'b01, 4'hF, 1, "R11 R3 restart ignored");
    // R5 refused encodings
    run_op(v, {8{32'h0BAD_C0DE}}, 2'b01, 4'h0, 0, "R5 fault ext128");
    run_op({8{32'hBF80_0000}}, {8{32'h5555_AAAA}}, 2'b10, 4'hE, 0, "R5 fault ext256");
    // R1 pseudo-random positive normals
    lcg = 32'h1357_9BDF;
    for (int k = 0; k < 6; k++) begin
      for (int i = 0; i < 8; i++) begin
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        v[i*32 +: 32] = {1'b0, (lcg[30:23] == 8'hFF) ? 8'hFE : lcg[30:23], lcg[22:0]};
      end
      run_op(v, '0, 2'b10, 4'hF, 0, "R1 random");
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule